// File: doc/BRIEF.md
# Port Edge Interrupt Controller

This block watches an eight-pin input port and turns selected signal transitions into interrupt requests. Each pin has its own two-bit trigger mode. The mode can ignore the pin, react to a low-to-high transition, react to a high-to-low transition, or react to either. A ninth channel takes one pin, picked by a three-bit selector, through a glitch-rejection stage. That stage accepts a new level only after the input has held it for a set number of clock cycles. The ninth channel has its own trigger mode.

Every pin first passes through a multi-flop synchronizer. Each channel that sees its configured transition sets a sticky pending bit. Software clears a pending bit by writing a one to it. A single interrupt line stays high while any pending bit is set. Configuration and pending state sit behind a small write/read register port with two word addresses.

Top module: `port_edge_irq`

## Requirements
- R1: After reset the configuration word (address 0) and the pending word (address 1) both read as zero, and `irq_o` is low.
- R2: Pin i is governed by configuration bits [2i+1:2i]. Mode 1 sets pending bit i on a rising edge of the pin, mode 2 sets it on a falling edge, and mode 3 sets it on either edge.
- R3: Mode 0 on a channel leaves its pending bit clear whatever the pin does.
- R4: The filtered channel takes its mode from configuration bits [17:16], using the same encoding as R2. Configuration bits [20:18] select the pin that feeds it. Its events set pending bit 8.
- R5: The filtered level follows the selected pin only after the synchronized pin has differed from it for FILT_CYCLES consecutive cycles. A pulse shorter than that produces no event on bit 8.
- R6: Writing address 1 clears every pending bit written as one and leaves bits written as zero unchanged.
- R7: When an edge event and a clear write hit the same pending bit in the same cycle, the bit stays set.
- R8: `irq_o` is high exactly when at least one pending bit is set.
- R9: Changing the selector on its own, with no pin activity, never sets pending bit 8, even when the newly selected pin sits at a different level.
- R10: Address 0 reads back the written configuration in bits [20:0]; bits 31:21 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 8 | Asynchronous port pins |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Word address: 0 configuration, 1 pending |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed word (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded properties check several rules on every cycle. A pending bit can only rise after a detected event. A clear never removes a bit that an event is setting. A cleared bit without an event goes to zero. The filter's output only ever moves to the level of the selected input. A reseed of the filter never produces an event. Whether the right mode bits steer the right pin, where the filter's acceptance threshold lies, and that a selector change stays silent at the pending word all depend on whole stimulus sequences. Only the bench's sweeps over pins, modes, pulse widths and selectors show those.

// File: rtl/pei_pkg.sv
package pei_pkg;
   localparam int unsigned MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      EDGE_OFF  = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2,
      EDGE_ANY  = 2'd3
   } edge_mode_e;
endpackage

// File: rtl/pei_sync.sv
module pei_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pei_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= async_i;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pei_edge_unit.sv
module pei_edge_unit
   import pei_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  edge_mode_e mode_i,
   input  logic       level_i,
   input  logic       mask_i,
   output logic       hit_o
);
   logic prev_q;
   logic rise, fall;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= level_i;
   end

   assign rise = level_i & ~prev_q;
   assign fall = ~level_i & prev_q;

   always_comb begin
      unique case (mode_i)
         EDGE_RISE: hit_o = rise;
         EDGE_FALL: hit_o = fall;
         EDGE_ANY:  hit_o = rise | fall;
         default:   hit_o = 1'b0;
      endcase
      if (mask_i) hit_o = 1'b0;
   end
endmodule

// File: rtl/pei_glitch_filter.sv
module pei_glitch_filter #(
   parameter int unsigned NUM_IN = 8,
   parameter int unsigned CYCLES = 6,
   localparam int unsigned SEL_W = $clog2(NUM_IN)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_IN-1:0] levels_i,
   input  logic [SEL_W-1:0]  sel_i,
   output logic              level_o,
   output logic              reseed_o
);
   if (NUM_IN < 2) begin : g_bad_inputs
      $error("pei_glitch_filter: NUM_IN must be at least 2");
   end
   if (CYCLES < 1) begin : g_bad_cycles
      $error("pei_glitch_filter: CYCLES must be at least 1");
   end

   logic [SEL_W-1:0] sel_q;
   logic             level_q;
   logic             reseed_q;
   logic             cur;
   logic             sel_change;

   assign cur        = levels_i[sel_i];
   assign sel_change = (sel_i != sel_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q    <= '0;
         reseed_q <= 1'b0;
      end else begin
         sel_q    <= sel_i;
         reseed_q <= sel_change;
      end
   end

   if (CYCLES == 1) begin : g_direct
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) level_q <= 1'b0;
         else         level_q <= cur;
      end
   end else begin : g_counted
      localparam int unsigned CNT_W = $clog2(CYCLES);
      localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYCLES - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            level_q <= 1'b0;
            cnt_q   <= '0;
         end else if (sel_change) begin
            level_q <= cur;
            cnt_q   <= '0;
         end else if (cur == level_q) begin
            cnt_q   <= '0;
         end else if (cnt_q == CNT_LAST) begin
            level_q <= cur;
            cnt_q   <= '0;
         end else begin
            cnt_q   <= cnt_q + 1'b1;
         end
      end
   end

   assign level_o  = level_q;
   assign reseed_o = reseed_q;

   // Filtered level may only move towards the input that was selected.
   assert_filter_tracks_input_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (level_q != $past(level_q)) |-> (level_q == $past(cur)));
endmodule

// File: rtl/port_edge_irq.sv
module port_edge_irq
   import pei_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 8,
   parameter int unsigned FILT_CYCLES = 6,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DATA_W      = 32
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_PINS-1:0] pins_i,
   input  logic                reg_we_i,
   input  logic                reg_addr_i,
   input  logic [DATA_W-1:0]   reg_wdata_i,
   output logic [DATA_W-1:0]   reg_rdata_o,
   output logic                irq_o
);
   localparam int unsigned SEL_W     = $clog2(NUM_PINS);
   localparam int unsigned NUM_CH    = NUM_PINS + 1;
   localparam int unsigned FMODE_LSB = MODE_W * NUM_PINS;
   localparam int unsigned FSEL_LSB  = FMODE_LSB + MODE_W;
   localparam int unsigned CFG_W     = FSEL_LSB + SEL_W;

   if (CFG_W > DATA_W) begin : g_bad_width
      $error("port_edge_irq: configuration does not fit the data word");
   end
   if (NUM_CH > DATA_W) begin : g_bad_channels
      $error("port_edge_irq: pending bits do not fit the data word");
   end

   logic [CFG_W-1:0]    cfg_q;
   logic [NUM_CH-1:0]   status_q;
   logic [NUM_CH-1:0]   hit_v;
   logic [NUM_CH-1:0]   clr_v;
   logic [NUM_PINS-1:0] pins_sync;
   logic                filt_level;
   logic                filt_reseed;
   logic                unused_wdata;

   assign unused_wdata = ^reg_wdata_i[DATA_W-1:CFG_W];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      cfg_q <= '0;
      else if (reg_we_i && !reg_addr_i) cfg_q <= reg_wdata_i[CFG_W-1:0];
   end

   pei_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (pins_i),
      .sync_o  (pins_sync)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      pei_edge_unit u_edge (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .mode_i  (edge_mode_e'(cfg_q[MODE_W*i +: MODE_W])),
         .level_i (pins_sync[i]),
         .mask_i  (1'b0),
         .hit_o   (hit_v[i])
      );
   end

   pei_glitch_filter #(.NUM_IN(NUM_PINS), .CYCLES(FILT_CYCLES)) u_filt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .levels_i (pins_sync),
      .sel_i    (cfg_q[FSEL_LSB +: SEL_W]),
      .level_o  (filt_level),
      .reseed_o (filt_reseed)
   );

   pei_edge_unit u_filt_edge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .mode_i  (edge_mode_e'(cfg_q[FMODE_LSB +: MODE_W])),
      .level_i (filt_level),
      .mask_i  (filt_reseed),
      .hit_o   (hit_v[NUM_PINS])
   );

   assign clr_v = (reg_we_i && reg_addr_i) ? reg_wdata_i[NUM_CH-1:0] : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_q <= '0;
      else         status_q <= hit_v | (status_q & ~clr_v);
   end

   always_comb begin
      reg_rdata_o = '0;
      if (reg_addr_i) reg_rdata_o[NUM_CH-1:0] = status_q;
      else            reg_rdata_o[CFG_W-1:0]  = cfg_q;
   end

   assign irq_o = |status_q;

   // A pending bit rises only after its channel reported an event.
   assert_set_needs_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((status_q & ~$past(status_q) & ~$past(hit_v)) == '0));
   // An event always lands, even against a clear.
   assert_edge_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (($past(hit_v) & ~status_q) == '0));
   // A clear without a competing event empties the bit.
   assert_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (($past(clr_v & ~hit_v) & status_q) == '0));
   // A reseeded filter level never counts as an event.
   assert_no_reseed_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      filt_reseed |-> !hit_v[NUM_PINS]);
endmodule

// File: tb/port_edge_irq_tb_top.sv
module port_edge_irq_tb_top;
   localparam int FILT = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  pins = '0;
   logic        we = 1'b0;
   logic        addr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int  vec_cnt = 0;
   int  err_cnt = 0;
   bit  done = 0;

   always #4 clk = ~clk;

   port_edge_irq #(.FILT_CYCLES(FILT)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .reg_we_i(we),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      vec_cnt++;
      if (act !== exp) begin
         err_cnt++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic a, logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(logic a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] filt_cfg(int sel, int mode);
      return (32'(sel) << 18) | (32'(mode) << 16);
   endfunction

   initial begin
      logic [31:0] v, exp;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      rd(1'b0, v); check("R1 cfg", v, 32'h0);
      rd(1'b1, v); check("R1 status", v, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);

      // R2 / R3 / R8: every pin, every mode, both directions
      for (int p = 0; p < 8; p++) begin
         for (int m = 0; m < 4; m++) begin
            wr(1'b0, 32'(m) << (2 * p));
            wr(1'b1, 32'h1FF);
            pins[p] = 1'b1;
            idle(5);
            exp = (m == 1 || m == 3) ? (32'h1 << p) : 32'h0;
            rd(1'b1, v); check(m == 0 ? "R3 rise" : "R2 rise", v, exp);
            check("R8 irq", {31'b0, irq}, {31'b0, exp != 0});
            wr(1'b1, 32'h1FF);
            pins[p] = 1'b0;
            idle(5);
            exp = (m == 2 || m == 3) ? (32'h1 << p) : 32'h0;
            rd(1'b1, v); check(m == 0 ? "R3 fall" : "R2 fall", v, exp);
            check("R8 irq", {31'b0, irq}, {31'b0, exp != 0});
            wr(1'b1, 32'h1FF);
         end
      end

      // R6: zeros keep bits, ones clear them
      wr(1'b0, 32'h3);
      pins[0] = 1'b1; idle(5);
      wr(1'b1, 32'h0);
      rd(1'b1, v); check("R6 zero write keeps", v, 32'h1);
      wr(1'b1, 32'h1);
      rd(1'b1, v); check("R6 one write clears", v, 32'h0);

      // R7: falling edge lands in the same cycle as the clear
      pins[0] = 1'b0;              // before first sync edge
      @(negedge clk);              // stage 1 captured
      @(negedge clk);              // stage 2 captured, event pending this cycle
      we = 1'b1; addr = 1'b1; wdata = 32'h1;
      @(negedge clk);
      we = 1'b0;
      rd(1'b1, v); check("R7 edge beats clear", v, 32'h1);
      wr(1'b1, 32'h1FF);
      wr(1'b0, 32'h0);

      // R5 / R4: filter threshold sweep, rising mode, every selector
      for (int s = 0; s < 8; s++) begin
         for (int k = 0; k < 4; k++) begin
            int w;
            w = FILT - 2 + k;
            wr(1'b0, filt_cfg(s, 1));
            wr(1'b1, 32'h1FF);
            idle(4);
            pins[s] = 1'b1;
            idle(w);
            pins[s] = 1'b0;
            idle(FILT + 8);
            exp = (w >= FILT) ? 32'h100 : 32'h0;
            rd(1'b1, v); check("R5 pulse width", v, exp);
         end
      end

      // R4: falling mode on filtered channel, selector 3
      wr(1'b0, filt_cfg(3, 2));
      wr(1'b1, 32'h1FF);
      pins[3] = 1'b1; idle(FILT + 8);
      rd(1'b1, v); check("R4 rise ignored in fall mode", v, 32'h0);
      pins[3] = 1'b0; idle(FILT + 8);
      rd(1'b1, v); check("R4 fall detected", v, 32'h100);
      wr(1'b1, 32'h1FF);

      // R9: selector switch alone stays silent
      wr(1'b0, filt_cfg(0, 3));
      pins[5] = 1'b1; idle(FILT + 8);
      wr(1'b1, 32'h1FF);
      rd(1'b1, v); check("R9 unselected pin", v, 32'h0);
      wr(1'b0, filt_cfg(5, 3)); idle(FILT + 8);
      rd(1'b1, v); check("R9 switch to high pin", v, 32'h0);
      wr(1'b0, filt_cfg(0, 3)); idle(FILT + 8);
      rd(1'b1, v); check("R9 switch back to low pin", v, 32'h0);
      pins[5] = 1'b0; idle(FILT + 8);

      // R10: readback width
      wr(1'b0, 32'hFFFF_FFFF);
      rd(1'b0, v); check("R10 readback", v, 32'h001F_FFFF);
      wr(1'b0, 32'h0);
      wr(1'b1, 32'h1FF);
      rd(1'b1, v); check("R10 status clean", v, 32'h0);

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         vec_cnt++;
         err_cnt++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
         $finish;
      end
   end
endmodule